// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block is a small, fully associative translation cache that a processor core consults on every memory access. Each slot holds one mapping from a virtual page to a physical frame. The mapping is tagged with an address-space identifier and carries four flags: valid, writable, global (shared by all address spaces) and uncached. A lookup presents a 32-bit virtual address, the access kind (load or store), the privilege mode and the current address-space identifier. The block compares the address against every slot in the same cycle. One clock later it returns either a translated physical address together with an uncached indication, or one exception code.

The block never walks page tables. Privileged software loads any slot directly through an indexed write port. Software does this after a miss exception and then retries the faulting access. A flush input invalidates every slot at once, which suits a context switch. The upper half of the address space is treated as privileged: a user-mode access there is rejected before translation is attempted. Kernel-mode accesses to any address go through the slots as usual.

Top module: `sw_tlb`

## Requirements
- R1: After a synchronous active-low reset, `rsp_vld` is 0 and every slot is invalid, so the first lookup that follows reports a miss.
- R2: The result of a lookup appears on the clock edge after the one that sampled `req_vld`=1, with `rsp_vld`=1. A cycle with `req_vld`=0 produces `rsp_vld`=0, `rsp_exc`=0, `rsp_pa`=0 and `rsp_uncached`=0 on the next edge.
- R3: A user-mode lookup (`req_user`=1) whose address bit 31 is 1 returns exception code 1 (address error), whatever the slots contain.
- R4: If no slot holds the requested page number (address bits 31:12), the lookup returns exception code 2 (miss).
- R5: A slot whose page number matches but whose identifier differs from `req_pid` is a candidate only if its global flag is set. A global slot matches under any identifier.
- R6: If the winning candidate slot has its valid flag clear, the lookup returns code 2, even when a higher-index valid candidate exists.
- R7: A store (`req_store`=1) that hits a slot with its writable flag clear returns code 3 (modification). A load that hits the same slot translates normally.
- R8: A successful lookup returns code 0 and `rsp_pa` = {frame number, address bits 11:0}.
- R9: `rsp_uncached` equals the winning slot's uncached flag on a successful lookup and is 0 whenever any exception code is returned. `rsp_pa` is 0 with any exception.
- R10: When several slots are candidates, the one with the lowest index decides the result.
- R11: `flush`=1 clears every valid flag on that edge. A write in the same cycle still installs its slot with the valid flag it carries.
- R12: A write to slot `wr_idx` takes effect on the clock edge. A lookup in the same cycle sees the previous contents of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all slots |
| wr_en | input | 1 | Load slot `wr_idx` this cycle |
| wr_idx | input | 6 | Slot index to load |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_pid | input | 6 | Address-space identifier to store |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_valid | input | 1 | Valid flag to store |
| wr_writable | input | 1 | Writable flag to store |
| wr_global | input | 1 | Global flag to store |
| wr_nocache | input | 1 | Uncached flag to store |
| req_vld | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | 1 = user mode |
| req_pid | input | 6 | Current address-space identifier |
| rsp_vld | output | 1 | Result valid (one cycle after request) |
| rsp_pa | output | 32 | Physical address (0 on exception) |
| rsp_uncached | output | 1 | Access must bypass the cache |
| rsp_exc | output | 2 | 0 none, 1 address error, 2 miss, 3 modification |

## Verification
A corrupted valid flag or stale slot shows up on the very next lookup that touches that page. It appears either as a miss where a translation was expected, or as a wrong frame in `rsp_pa`, exactly one cycle after the request. A wrong candidate choice among duplicate slots only shows when duplicates exist, so the bench loads them on purpose and also stores a stale entry below a valid one. A flush that leaves state behind shows up as a hit on the first lookup of the old page after the flush. The bench compares every response against a behavioural model each clock, so any divergence is caught in the cycle in which it first reaches the ports.

// File: rtl/sw_tlb_pkg.sv
// Shared widths, slot layout and result codes for the translation cache.
// Assumes a 32-bit virtual address split into page number and page offset.
package sw_tlb_pkg;
    parameter int VPN_W = 20;
    parameter int OFF_W = 12;
    parameter int PID_W = 6;
    parameter int PFN_W = 20;
    localparam int VA_W = VPN_W + OFF_W;
    localparam int PA_W = PFN_W + OFF_W;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_ADDR = 2'd1,
        EXC_MISS = 2'd2,
        EXC_MOD  = 2'd3
    } tlb_exc_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PID_W-1:0] pid;
        logic [PFN_W-1:0] pfn;
        logic             writable;
        logic             glb;
        logic             nocache;
    } tlb_slot_t;
endpackage

// File: rtl/tlb_slot_store.sv
// Slot storage: payload registers without reset and valid flags with reset.
// Assumes at most one indexed write per cycle. A flush clears all valid flags,
// and a write in the same cycle lands after the flush.
module tlb_slot_store
    import sw_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_slot_t        wr_slot,
    input  logic             wr_valid,
    output tlb_slot_t        slot_q [ENTRIES],
    output logic [ENTRIES-1:0] vld_q
);
    // Payload write: only the addressed slot changes.
    always_ff @(posedge clk) begin
        if (wr_en) slot_q[wr_idx] <= wr_slot;
    end

    // Valid flags: reset and flush clear all, then the write sets its own flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (flush) vld_q <= '0;
            if (wr_en) vld_q[wr_idx] <= wr_valid;
        end
    end

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !wr_en |=> vld_q == '0);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> vld_q == '0);
endmodule

// File: rtl/tlb_cam_match.sv
// Parallel tag compare over all slots and a lowest-index winner select.
// A slot is a candidate when its page number matches and either its
// identifier matches or its global flag is set; the valid flag is not
// part of the candidate test, so a stale low slot masks higher ones.
module tlb_cam_match
    import sw_tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tlb_slot_t          slot_q [ENTRIES],
    input  logic [ENTRIES-1:0] vld_q,
    input  logic [VPN_W-1:0]   look_vpn,
    input  logic [PID_W-1:0]   look_pid,
    output logic               any_cand,
    output tlb_slot_t          win_slot,
    output logic               win_vld
);
    logic [ENTRIES-1:0] cand;
    logic [ENTRIES-1:0] win_oh;

    // Per-slot compare, one comparator pair per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign cand[g] = (slot_q[g].vpn == look_vpn) &&
                         (slot_q[g].glb || (slot_q[g].pid == look_pid));
    end

    // Lowest-index priority: isolate the least significant set bit.
    assign win_oh   = cand & (~cand + 1'b1);
    assign any_cand = |cand;

    // One-hot mux of the winning slot and its valid flag.
    always_comb begin
        win_slot = '0;
        win_vld  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (win_oh[i]) begin
                win_slot = slot_q[i];
                win_vld  = vld_q[i];
            end
        end
    end

    // R10
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh));
    // R4
    cand_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_cand |-> $countones(win_oh) == 1);
endmodule

// File: rtl/tlb_resolve.sv
// Fixed-priority result builder: address error, then miss (no candidate or
// stale winner), then store to a read-only page, else translation.
// Assumes the upper half of the address space is privileged.
module tlb_resolve
    import sw_tlb_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic            is_store,
    input  logic            is_user,
    input  logic            any_cand,
    input  tlb_slot_t       win_slot,
    input  logic            win_vld,
    output tlb_exc_e        exc,
    output logic [PA_W-1:0] pa,
    output logic            uncached
);
    // Priority chain evaluated in one combinational pass.
    always_comb begin
        if (is_user && va[VA_W-1])            exc = EXC_ADDR;
        else if (!any_cand || !win_vld)       exc = EXC_MISS;
        else if (is_store && !win_slot.writable) exc = EXC_MOD;
        else                                  exc = EXC_NONE;
    end

    // Address and uncached output only on a clean translation.
    assign pa       = (exc == EXC_NONE) ? {win_slot.pfn, va[OFF_W-1:0]} : '0;
    assign uncached = (exc == EXC_NONE) && win_slot.nocache;
endmodule

// File: rtl/sw_tlb.sv
// Top of the software-refilled translation cache. Compares all slots in the
// lookup cycle and registers the result on the next edge. Assumes software
// handles refill and that writes and lookups in the same cycle see old data.
module sw_tlb
    import sw_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [VPN_W-1:0]      wr_vpn,
    input  logic [PID_W-1:0]      wr_pid,
    input  logic [PFN_W-1:0]      wr_pfn,
    input  logic                  wr_valid,
    input  logic                  wr_writable,
    input  logic                  wr_global,
    input  logic                  wr_nocache,
    input  logic                  req_vld,
    input  logic [VA_W-1:0]       req_va,
    input  logic                  req_store,
    input  logic                  req_user,
    input  logic [PID_W-1:0]      req_pid,
    output logic                  rsp_vld,
    output logic [PA_W-1:0]       rsp_pa,
    output logic                  rsp_uncached,
    output logic [1:0]            rsp_exc
);
    tlb_slot_t          wr_slot;
    tlb_slot_t          slot_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic               any_cand;
    tlb_slot_t          win_slot;
    logic               win_vld;
    tlb_exc_e           exc_d;
    logic [PA_W-1:0]    pa_d;
    logic               unc_d;

    // Pack the write-port fields into one slot word.
    always_comb begin
        wr_slot.vpn      = wr_vpn;
        wr_slot.pid      = wr_pid;
        wr_slot.pfn      = wr_pfn;
        wr_slot.writable = wr_writable;
        wr_slot.glb      = wr_global;
        wr_slot.nocache  = wr_nocache;
    end

    tlb_slot_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_slot(wr_slot), .wr_valid(wr_valid),
        .slot_q(slot_q), .vld_q(vld_q)
    );

    tlb_cam_match #(.ENTRIES(ENTRIES)) u_match (
        .clk(clk), .rst_n(rst_n), .slot_q(slot_q), .vld_q(vld_q),
        .look_vpn(req_va[VA_W-1:OFF_W]), .look_pid(req_pid),
        .any_cand(any_cand), .win_slot(win_slot), .win_vld(win_vld)
    );

    tlb_resolve u_resolve (
        .va(req_va), .is_store(req_store), .is_user(req_user),
        .any_cand(any_cand), .win_slot(win_slot), .win_vld(win_vld),
        .exc(exc_d), .pa(pa_d), .uncached(unc_d)
    );

    // Result register: captures a lookup, or clears when no request.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_vld) begin
            rsp_vld      <= 1'b0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            rsp_exc      <= EXC_NONE;
        end else begin
            rsp_vld      <= 1'b1;
            rsp_pa       <= pa_d;
            rsp_uncached <= unc_d;
            rsp_exc      <= exc_d;
        end
    end

    // R3
    addr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && req_user && req_va[VA_W-1] |=> rsp_exc == EXC_ADDR);
    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld && rsp_exc == EXC_NONE);
    // R9
    unc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_uncached |-> rsp_exc == EXC_NONE && rsp_vld);
    // R9
    pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc != EXC_NONE |-> rsp_pa == '0);
endmodule

// File: tb/sw_tlb_bench.sv
module sw_tlb_bench;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush, wr_en, wr_valid, wr_writable, wr_global, wr_nocache;
    logic [5:0]  wr_idx, wr_pid, req_pid;
    logic [19:0] wr_vpn, wr_pfn;
    logic        req_vld, req_store, req_user;
    logic [31:0] req_va;
    logic        rsp_vld, rsp_uncached;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_exc;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit   live = 1'b0;

    // behavioural reference state
    logic [19:0] m_vpn [N];
    logic [5:0]  m_pid [N];
    logic [19:0] m_pfn [N];
    bit          m_v [N], m_w [N], m_g [N], m_n [N];
    bit          e_vld, e_unc;
    logic [31:0] e_pa;
    logic [1:0]  e_exc;

    always #4 clk = ~clk;

    sw_tlb u_sw_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_pid(wr_pid), .wr_pfn(wr_pfn), .wr_valid(wr_valid),
        .wr_writable(wr_writable), .wr_global(wr_global), .wr_nocache(wr_nocache),
        .req_vld(req_vld), .req_va(req_va), .req_store(req_store),
        .req_user(req_user), .req_pid(req_pid), .rsp_vld(rsp_vld),
        .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached), .rsp_exc(rsp_exc)
    );

    // reference model: result of this edge from old table, then table update
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            e_vld = 0; e_unc = 0; e_pa = 0; e_exc = 0;
        end else begin
            e_vld = req_vld; e_unc = 0; e_pa = 0; e_exc = 0;
            if (req_vld) begin
                int hit;
                hit = -1;
                for (int i = N - 1; i >= 0; i--)
                    if (m_vpn[i] == req_va[31:12] && (m_g[i] || m_pid[i] == req_pid))
                        hit = i;
                if (req_user && req_va[31]) e_exc = 1;
                else if (hit < 0 || !m_v[hit]) e_exc = 2;
                else if (req_store && !m_w[hit]) e_exc = 3;
                else begin
                    e_pa  = {m_pfn[hit], req_va[11:0]};
                    e_unc = m_n[hit];
                end
            end
            if (flush) for (int i = 0; i < N; i++) m_v[i] = 0;
            if (wr_en) begin
                m_vpn[wr_idx] = wr_vpn; m_pid[wr_idx] = wr_pid; m_pfn[wr_idx] = wr_pfn;
                m_v[wr_idx] = wr_valid; m_w[wr_idx] = wr_writable;
                m_g[wr_idx] = wr_global; m_n[wr_idx] = wr_nocache;
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    // per-cycle model compare
    always @(negedge clk) begin
        if (live) begin
            chk({tag, " rsp_vld"}, {31'd0, rsp_vld}, {31'd0, e_vld});
            chk({tag, " rsp_exc"}, {30'd0, rsp_exc}, {30'd0, e_exc});
            chk({tag, " rsp_pa"}, rsp_pa, e_pa);
            chk({tag, " rsp_uncached"}, {31'd0, rsp_uncached}, {31'd0, e_unc});
        end
    end

    task automatic idle();
        flush = 0; wr_en = 0; wr_idx = 0; wr_vpn = 0; wr_pid = 0; wr_pfn = 0;
        wr_valid = 0; wr_writable = 0; wr_global = 0; wr_nocache = 0;
        req_vld = 0; req_va = 0; req_store = 0; req_user = 0; req_pid = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic put(input int idx, input logic [19:0] vpn, input logic [5:0] pid,
                       input logic [19:0] pfn, input bit v, input bit w, input bit g, input bit n);
        wr_en = 1; wr_idx = idx[5:0]; wr_vpn = vpn; wr_pid = pid; wr_pfn = pfn;
        wr_valid = v; wr_writable = w; wr_global = g; wr_nocache = n;
    endtask

    task automatic look(input logic [31:0] va, input bit st, input bit usr, input logic [5:0] pid);
        req_vld = 1; req_va = va; req_store = st; req_user = usr; req_pid = pid;
    endtask

    task automatic expect_rsp(input string t, input logic [1:0] exc, input logic [31:0] pa, input bit unc);
        chk({t, " exc"}, {30'd0, rsp_exc}, {30'd0, exc});
        chk({t, " pa"}, rsp_pa, pa);
        chk({t, " unc"}, {31'd0, rsp_uncached}, {31'd0, unc});
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        live = 1;
        // R1: reset state
        chk("R1 rsp_vld after reset", {31'd0, rsp_vld}, 32'd0);
        tag = "R1"; look(32'h0000_1000, 0, 0, 0); tick(); idle();
        expect_rsp("R1/R4 empty table miss", 2, 0, 0);

        // R12: write and lookup of same page in one cycle sees old content
        tag = "R12";
        put(5, 20'h00010, 6'd3, 20'hABCDE, 1, 1, 0, 0);
        look(32'h0001_0123, 0, 0, 6'd3); tick(); idle();
        expect_rsp("R12 same-cycle write", 2, 0, 0);
        tag = "R8"; look(32'h0001_0123, 0, 0, 6'd3); tick(); idle();
        expect_rsp("R8 hit", 0, 32'hABCDE123, 0);
        tag = "R8"; look(32'h0001_0FFF, 1, 1, 6'd3); tick(); idle();
        expect_rsp("R8 user store hit", 0, 32'hABCDEFFF, 0);

        // R5: identifier mismatch, and global slot
        tag = "R5"; look(32'h0001_0123, 0, 0, 6'd4); tick(); idle();
        expect_rsp("R5 pid mismatch", 2, 0, 0);
        put(7, 20'h00020, 6'd0, 20'h11111, 1, 0, 1, 1); tick(); idle();
        look(32'h0002_0456, 0, 1, 6'd9); tick(); idle();
        expect_rsp("R5/R9 global uncached hit", 0, 32'h11111456, 1);
        tag = "R7"; look(32'h0002_0456, 1, 1, 6'd9); tick(); idle();
        expect_rsp("R7 store read-only", 3, 0, 0);

        // R3: user access to upper half
        tag = "R3"; put(2, 20'h80000, 6'd1, 20'h22222, 1, 1, 0, 0); tick(); idle();
        look(32'h8000_0010, 0, 1, 6'd1); tick(); idle();
        expect_rsp("R3 user high address", 1, 0, 0);
        look(32'h8000_0010, 0, 0, 6'd1); tick(); idle();
        expect_rsp("R3 kernel high address translated", 0, 32'h22222010, 0);
        look(32'hFFFF_F000, 1, 1, 6'd1); tick(); idle();
        expect_rsp("R3 user high unmapped still address error", 1, 0, 0);

        // R6/R10: stale low slot masks valid higher slot
        tag = "R6";
        put(1, 20'h00030, 6'd3, 20'h44444, 0, 1, 0, 0); tick(); idle();
        put(9, 20'h00030, 6'd3, 20'h99999, 1, 1, 0, 0); tick(); idle();
        look(32'h0003_0000, 0, 0, 6'd3); tick(); idle();
        expect_rsp("R6 stale winner miss", 2, 0, 0);
        tag = "R10";
        put(3, 20'h00040, 6'd3, 20'h33333, 1, 1, 0, 0); tick(); idle();
        put(8, 20'h00040, 6'd3, 20'h88888, 1, 1, 0, 1); tick(); idle();
        look(32'h0004_0ABC, 0, 0, 6'd3); tick(); idle();
        expect_rsp("R10 lowest index wins", 0, 32'h33333ABC, 0);

        // R11: flush with simultaneous write
        tag = "R11";
        flush = 1; put(10, 20'h00050, 6'd2, 20'h55555, 1, 1, 0, 0); tick(); idle();
        look(32'h0001_0123, 0, 0, 6'd3); tick(); idle();
        expect_rsp("R11 flushed slot", 2, 0, 0);
        look(32'h0005_0001, 0, 0, 6'd2); tick(); idle();
        expect_rsp("R11 write beside flush kept", 0, 32'h55555001, 0);

        // R2: no request gives idle response
        tag = "R2"; tick();
        chk("R2 idle rsp_vld", {31'd0, rsp_vld}, 32'd0);

        // mixed traffic on a small page space, model-compared each cycle
        tag = "RAND R4 R5 R7 R9 R10";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            idle();
            if (r < 25) put($urandom_range(0, N - 1), 20'($urandom_range(0, 7)),
                            6'($urandom_range(0, 3)), 20'($urandom),
                            $urandom_range(0, 3) != 0, $urandom_range(0, 1),
                            $urandom_range(0, 3) == 0, $urandom_range(0, 1));
            if (r == 99) flush = 1;
            if ($urandom_range(0, 3) != 0)
                look({($urandom_range(0, 7) == 0), 11'd0, 20'($urandom_range(0, 7)) % 20'h8, 12'($urandom)} >> 0,
                     $urandom_range(0, 1), $urandom_range(0, 1), 6'($urandom_range(0, 3)));
            tick();
        end
        idle(); tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule